// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This block works next to a 16550-compatible UART. It collects five interrupt causes: a receive line error, receive data at or above the fill threshold, receive character timeout, transmit holding register empty, and a modem line change. Each cause is held as pending until the event that clears it. The enabled causes are arbitrated by fixed priority, and the winner appears as a 4-bit identification code in an 8-bit identification byte. A single interrupt line is raised while any enabled cause is pending.

The host read and write strobes of the UART drive the clear events. The receive FIFO level, the push and pop strobes, and a character-time tick drive the receive-side causes. The block does not contain the serializer, the baud generator or the FIFO storage.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, and with FIFO mode off, `id_reg` reads 8'h01 and `irq` is low. A code value of 4'b0001 means that nothing is pending.
- R2: A `line_err` pulse makes the line-status cause pending with code 4'b0110, which has the highest priority. A `linestat_rd` pulse clears it.
- R3: The data-available cause (code 4'b0100) is pending one cycle after `rx_level` is at or above the threshold, and is not pending one cycle after the level falls below it. In FIFO mode the threshold follows `trig_sel`: 0→1, 1→4, 2→8, 3→14 bytes. Outside FIFO mode the threshold is 1.
- R4: The timeout cause (code 4'b1100) is raised in FIFO mode on the fourth `char_tick` counted since the last `rx_push`, `rx_pop` or `rxbuf_rd` while `rx_level` is nonzero. Any of those strobes clears it and restarts the count, and so does an empty FIFO or leaving FIFO mode. When data-available and timeout are both enabled and pending, data-available is reported.
- R5: A `tx_empty_evt` pulse makes the transmit-empty cause pending with code 4'b0010, which has the third priority. A `txhold_wr` pulse clears it. An `id_rd` pulse clears it only when 4'b0010 is the code shown in that cycle.
- R6: A `modem_chg` pulse makes the modem cause pending with code 4'b0000, which has the lowest priority. A `modemstat_rd` pulse clears it.
- R7: `src_en` bit 0 enables line status, bit 1 data available, bit 2 timeout, bit 3 transmit empty and bit 4 modem. A disabled cause is not reported, but it stays pending and is reported as soon as it is enabled.
- R8: `id_reg[7:6]` both equal `fifo_mode`, and `id_reg[5:4]` read 0.
- R9: `irq` is always the inverse of `id_reg[0]`.
- R10: When a set pulse and a clear pulse for the same line-status, transmit-empty or modem cause arrive in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | FIFO mode enabled |
| trig_sel | input | 2 | Receive threshold select |
| src_en | input | 5 | Per-cause enables |
| line_err | input | 1 | Overrun, parity, framing or break seen |
| linestat_rd | input | 1 | Line status register read |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | Character written into receive FIFO |
| rx_pop | input | 1 | Character removed from receive FIFO |
| rxbuf_rd | input | 1 | Receive buffer read |
| char_tick | input | 1 | One character time elapsed |
| tx_empty_evt | input | 1 | Transmit holding register became empty |
| txhold_wr | input | 1 | Transmit holding register write |
| id_rd | input | 1 | Identification register read |
| modem_chg | input | 1 | CTS, DSR, RI or DCD changed |
| modemstat_rd | input | 1 | Modem status register read |
| id_reg | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the one where all five causes are pending together. Getting there needs a nonzero FIFO level at the lowest threshold and four idle character ticks with no push or pop, so that timeout and data-available coexist with the three strobe-raised causes. The bench builds that state once and then sweeps all 32 enable masks against a priority model. It then clears the causes one at a time. This includes an identification read taken while a higher cause hides transmit-empty, which must leave transmit-empty pending.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 5;
  localparam int SRC_LINE = 0;
  localparam int SRC_RXDATA = 1;
  localparam int SRC_TMO = 2;
  localparam int SRC_TXE = 3;
  localparam int SRC_MODEM = 4;

  localparam logic [3:0] IID_NONE    = 4'b0001;
  localparam logic [3:0] IID_LINE    = 4'b0110;
  localparam logic [3:0] IID_RXDATA  = 4'b0100;
  localparam logic [3:0] IID_TMO     = 4'b1100;
  localparam logic [3:0] IID_TXEMPTY = 4'b0010;
  localparam logic [3:0] IID_MODEM   = 4'b0000;

  function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_bytes = 5'd1;
      2'd1:    trig_bytes = 5'd4;
      2'd2:    trig_bytes = 5'd8;
      default: trig_bytes = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_evt,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst)             flag_q <= 1'b0;
      else if (set_evt[i]) flag_q <= 1'b1;
      else if (clr_evt[i]) flag_q <= 1'b0;
    end
    assign pend[i] = flag_q;

    // set beats a simultaneous clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> pend[i]);
    // clear without set drops the flag (covers R2, R5, R6)
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
      (clr_evt[i] && !set_evt[i]) |=> !pend[i]);
  end
endmodule

// File: rtl/uart_irq_rxmon.sv
module uart_irq_rxmon
  import uart_irq_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic [1:0]       trig_sel,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rxbuf_rd,
  input  logic             char_tick,
  output logic             rda_pend,
  output logic             tmo_pend
);
  localparam int CNT_W = $clog2(TO_CHARS + 1);

  logic [4:0]       thr_c;
  logic             rda_q;
  logic             tmo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             restart_c;

  assign thr_c = fifo_mode ? trig_bytes(trig_sel) : 5'd1;

  always_ff @(posedge clk) begin
    if (rst) rda_q <= 1'b0;
    else     rda_q <= (int'(rx_level) >= int'(thr_c));
  end

  assign restart_c = !fifo_mode || (rx_level == '0) || rx_push || rx_pop || rxbuf_rd;

  always_ff @(posedge clk) begin
    if (rst || restart_c) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (char_tick && !tmo_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(TO_CHARS - 1)) tmo_q <= 1'b1;
    end
  end

  assign rda_pend = rda_q;
  assign tmo_pend = tmo_q;

  p_rda_empty_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !rda_pend);
  p_tmo_empty_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !tmo_pend);
  p_tmo_mode_r4: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |=> !tmo_pend);
  p_tmo_count_r4: assert property (@(posedge clk) disable iff (rst)
    tmo_pend |-> (cnt_q == CNT_W'(TO_CHARS)));
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] en,
  output logic [3:0]      iid
);
  logic [NSRC-1:0] act_c;
  assign act_c = pend & en;

  always_comb begin
    if (act_c[SRC_LINE])        iid = IID_LINE;
    else if (act_c[SRC_RXDATA]) iid = IID_RXDATA;
    else if (act_c[SRC_TMO])    iid = IID_TMO;
    else if (act_c[SRC_TXE])    iid = IID_TXEMPTY;
    else if (act_c[SRC_MODEM])  iid = IID_MODEM;
    else                        iid = IID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic [1:0]       trig_sel,
  input  logic [4:0]       src_en,
  input  logic             line_err,
  input  logic             linestat_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rxbuf_rd,
  input  logic             char_tick,
  input  logic             tx_empty_evt,
  input  logic             txhold_wr,
  input  logic             id_rd,
  input  logic             modem_chg,
  input  logic             modemstat_rd,
  output logic [7:0]       id_reg,
  output logic             irq
);
  localparam int NSTICKY = 3;

  logic [NSRC-1:0]    pend;
  logic [NSTICKY-1:0] st_set, st_clr, st_pend;
  logic [3:0]         iid;
  logic               rda_p, tmo_p;

  // sticky order: 0 line status, 1 transmit empty, 2 modem
  assign st_set = {modem_chg, tx_empty_evt, line_err};
  assign st_clr = {modemstat_rd, txhold_wr || (id_rd && iid == IID_TXEMPTY), linestat_rd};

  uart_irq_sticky #(.N(NSTICKY)) u_sticky (
    .clk(clk), .rst(rst), .set_evt(st_set), .clr_evt(st_clr), .pend(st_pend)
  );

  uart_irq_rxmon #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) u_rxmon (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
    .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .rxbuf_rd(rxbuf_rd), .char_tick(char_tick),
    .rda_pend(rda_p), .tmo_pend(tmo_p)
  );

  assign pend[SRC_LINE]   = st_pend[0];
  assign pend[SRC_RXDATA] = rda_p;
  assign pend[SRC_TMO]    = tmo_p;
  assign pend[SRC_TXE]    = st_pend[1];
  assign pend[SRC_MODEM]  = st_pend[2];

  uart_irq_arb u_arb (.pend(pend), .en(src_en), .iid(iid));

  assign id_reg = {fifo_mode, fifo_mode, 2'b00, iid};
  assign irq    = (pend & src_en) != '0;

  p_irq_code_r9: assert property (@(posedge clk) disable iff (rst)
    irq == !id_reg[0]);
  p_fifo_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (id_reg[7:6] == {2{fifo_mode}}) && (id_reg[5:4] == 2'b00));
  p_line_first_r2: assert property (@(posedge clk) disable iff (rst)
    (pend[SRC_LINE] && src_en[SRC_LINE]) |-> (id_reg[3:0] == IID_LINE));
  p_masked_none_r7: assert property (@(posedge clk) disable iff (rst)
    ((pend & src_en) == '0) |-> (id_reg[3:0] == IID_NONE));
  p_thre_hidden_r5: assert property (@(posedge clk) disable iff (rst)
    (pend[SRC_TXE] && id_rd && !txhold_wr && iid != IID_TXEMPTY) |=> pend[SRC_TXE]);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_mode = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [4:0] src_en = 5'd0;
  logic       line_err = 1'b0, linestat_rd = 1'b0;
  logic [4:0] rx_level = 5'd0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, rxbuf_rd = 1'b0, char_tick = 1'b0;
  logic       tx_empty_evt = 1'b0, txhold_wr = 1'b0, id_rd = 1'b0;
  logic       modem_chg = 1'b0, modemstat_rd = 1'b0;
  logic [7:0] id_reg;
  logic       irq;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_irq_ident u0 (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .trig_sel(trig_sel),
    .src_en(src_en), .line_err(line_err), .linestat_rd(linestat_rd),
    .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .rxbuf_rd(rxbuf_rd), .char_tick(char_tick), .tx_empty_evt(tx_empty_evt),
    .txhold_wr(txhold_wr), .id_rd(id_rd), .modem_chg(modem_chg),
    .modemstat_rd(modemstat_rd), .id_reg(id_reg), .irq(irq)
  );

  function automatic logic [3:0] exp_code(input logic [4:0] m, input logic [4:0] p);
    logic [4:0] a;
    a = m & p;
    if (a[0])      return 4'b0110;
    else if (a[1]) return 4'b0100;
    else if (a[2]) return 4'b1100;
    else if (a[3]) return 4'b0010;
    else if (a[4]) return 4'b0000;
    else           return 4'b0001;
  endfunction

  function automatic int thr_of(input logic fm, input logic [1:0] sel);
    if (!fm) return 1;
    case (sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] code);
    logic [7:0] e;
    #1;
    e = {fifo_mode, fifo_mode, 2'b00, code};
    n_chk++;
    if (id_reg !== e || irq !== (code != 4'b0001)) begin
      n_fail++;
      $display("FAIL %s: id_reg=%h irq=%b expected id_reg=%h irq=%b",
               req, id_reg, irq, e, code != 4'b0001);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1; step(); char_tick = 1'b0; step();
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    chk("R1 reset", 4'b0001);

    // R3 and R8: threshold sweep in both modes
    src_en = 5'b00010;
    for (int fm = 0; fm < 2; fm++)
      for (int sel = 0; sel < 4; sel++)
        for (int lv = 0; lv <= 16; lv++) begin
          fifo_mode = fm[0]; trig_sel = sel[1:0]; rx_level = lv[4:0];
          step();
          chk("R3 level", (lv >= thr_of(fm[0], sel[1:0])) ? 4'b0100 : 4'b0001);
        end
    rx_level = 5'd0; step();

    // all five pending
    fifo_mode = 1'b1; trig_sel = 2'd0; rx_level = 5'd3; step();
    line_err = 1'b1; tx_empty_evt = 1'b1; modem_chg = 1'b1; step();
    line_err = 1'b0; tx_empty_evt = 1'b0; modem_chg = 1'b0; step();
    ticks(4);
    // R7, R4 tie, R9: every enable mask
    for (int m = 0; m < 32; m++) begin
      src_en = m[4:0];
      chk("R7 mask", exp_code(m[4:0], 5'b11111));
    end

    src_en = 5'b11111;
    line_err = 1'b1; linestat_rd = 1'b1; step();
    line_err = 1'b0; linestat_rd = 1'b0; step();
    chk("R10 set wins", 4'b0110);
    linestat_rd = 1'b1; step(); linestat_rd = 1'b0; step();
    chk("R2 cleared", 4'b0100);
    src_en = 5'b11100;
    chk("R4 timeout", 4'b1100);
    id_rd = 1'b1; step(); id_rd = 1'b0; step();
    src_en = 5'b01000;
    chk("R5 hidden read keeps", 4'b0010);
    src_en = 5'b11100;
    rxbuf_rd = 1'b1; step(); rxbuf_rd = 1'b0; step();
    chk("R4 buffer read clears", 4'b0010);
    id_rd = 1'b1; step(); id_rd = 1'b0; step();
    chk("R5 shown read clears", 4'b0000);
    modemstat_rd = 1'b1; step(); modemstat_rd = 1'b0; step();
    chk("R6 cleared", 4'b0001);

    // R4 counting and restart
    src_en = 5'b00100;
    ticks(3);
    chk("R4 three ticks", 4'b0001);
    rx_push = 1'b1; step(); rx_push = 1'b0; step();
    ticks(3);
    chk("R4 restart on push", 4'b0001);
    ticks(1);
    chk("R4 fourth tick", 4'b1100);
    rx_level = 5'd0; step();
    chk("R4 empty clears", 4'b0001);
    fifo_mode = 1'b0; rx_level = 5'd2; step();
    ticks(5);
    chk("R4 no timeout outside fifo", 4'b0001);
    fifo_mode = 1'b1; rx_level = 5'd0; step();

    // R5 write clear, R10 on transmit empty
    src_en = 5'b01000;
    tx_empty_evt = 1'b1; step(); tx_empty_evt = 1'b0; step();
    chk("R5 set", 4'b0010);
    txhold_wr = 1'b1; step(); txhold_wr = 1'b0; step();
    chk("R5 write clears", 4'b0001);
    tx_empty_evt = 1'b1; txhold_wr = 1'b1; step();
    tx_empty_evt = 1'b0; txhold_wr = 1'b0; step();
    chk("R10 txe set wins", 4'b0010);
    txhold_wr = 1'b1; step(); txhold_wr = 1'b0; step();

    // R6 and R7 hidden then revealed
    src_en = 5'b00000;
    modem_chg = 1'b1; step(); modem_chg = 1'b0; step();
    chk("R7 disabled hidden", 4'b0001);
    src_en = 5'b10000;
    chk("R6 revealed", 4'b0000);
    modem_chg = 1'b1; modemstat_rd = 1'b1; step();
    modem_chg = 1'b0; modemstat_rd = 1'b0; step();
    chk("R10 modem set wins", 4'b0000);
    modemstat_rd = 1'b1; step(); modemstat_rd = 1'b0; step();
    chk("R6 read clears", 4'b0001);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule